// File: doc/BRIEF.md
# Windowed Performance Counter Unit

This block holds four independent event counters. Their counting is limited to a measurement window. Two event-match strobes, or a run-start strobe and a break strobe, open and close that window. The active pair of strobes depends on the window mode. Each counter has its own 4-bit source code, which picks one of these sources:

- elapsed clock cycles
- one of seven single-cycle event strobes: branches, executed instructions, executed 32-bit instructions, exceptions, interrupts, data cache misses and instruction cache misses

When a window closes, each counter keeps its total. If the window opens again, the counter adds to that total. A counter that would pass its maximum value stays at all-ones and sets a sticky overflow flag. Software reads the counts and the overflow flags through a small address-selected read port. A single-cycle initialize command clears all counts and flags.

The window is a two-state machine, `WIN_CLOSED` and `WIN_OPEN`:

- **`CLOSED -> OPEN`**: taken when the selected open strobe is high and the selected close strobe is low.
- **`OPEN -> CLOSED`**: taken when the close strobe is high and the open strobe is low.
- **Self-loops**: in every other case the machine keeps its state, including when both strobes are high in the same cycle.

Top module: `pwc_top`

## Requirements
- R1: Each of the four channels takes a 4-bit code from `src_sel[4*i+3:4*i]` for channel i. The codes are:
  - 0: off
  - 1: every cycle
  - 2: `ev_pulse[0]`, branch
  - 3: `ev_pulse[1]`, instruction
  - 4: `ev_pulse[2]`, 32-bit instruction
  - 5: `ev_pulse[3]`, exception
  - 6: `ev_pulse[4]`, interrupt
  - 7: `ev_pulse[5]`, data cache miss
  - 8: `ev_pulse[6]`, instruction cache miss
  - 9 to 15: count nothing

  All four channels count at the same time.
- R2: With `mode_sel` = 2'b00, `hit_ch2` opens the window and `hit_ch1` closes it. The run and break strobes are ignored.
- R3: With `mode_sel` = 2'b01, `hit_ch1` opens the window and `hit_ch2` closes it. The run and break strobes are ignored.
- R4: With `mode_sel[1]` = 1, `run_start` opens the window and `brk_evt` closes it. Both match strobes are ignored.
- R5: A counter advances by one at a clock edge only if two things hold before that edge: `win_open` was 1, and the channel's source was active in that cycle. An event in the cycle that opens the window is not counted. An event in the cycle that closes the window is counted.
- R6: After a window closes, its counts are kept. Reopening the window adds to those totals.
- R7: An open strobe and a close strobe in the same cycle leave `win_open` unchanged. An open strobe while the window is open, or a close strobe while it is closed, also has no effect.
- R8: When an increment would go past all-ones, the counter stays at all-ones and its overflow flag becomes 1. The flag stays set until initialize.
- R9: `init_cmd` clears every count and overflow flag at the next edge. It takes priority over a same-cycle increment and does not change `win_open`.
- R10: The read port is combinational:
  - `rd_addr` 0 to 3 returns the count of that channel.
  - `rd_addr` 4 returns the overflow flags in bits [3:0], with channel i in bit i.
  - `rd_addr` 5 to 7 return zero.
- R11: After reset, all counts and flags are zero and the window is closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Window mode: 00 ch2 to ch1, 01 ch1 to ch2, 1x run to break |
| hit_ch1 | input | 1 | Event-match strobe of channel 1 |
| hit_ch2 | input | 1 | Event-match strobe of channel 2 |
| run_start | input | 1 | Program-run start strobe |
| brk_evt | input | 1 | Break strobe |
| ev_pulse | input | 7 | Event strobes, bit mapping as in R1 |
| src_sel | input | 16 | Four 4-bit source codes |
| init_cmd | input | 1 | Clear all counts and flags |
| rd_addr | input | 3 | Read select |
| rd_data | output | 32 | Selected count or flag word |
| win_open | output | 1 | Measurement window is open |

## Verification
The assertions assume three things about the inputs:
- Reset is low at time zero.
- Every strobe and code input holds a defined 0 or 1 at each rising edge.
- `init_cmd` is a level that is sampled only at the edge.

The bench meets these conditions in two ways. It starts with reset low and gives every input a known value before the first edge. It also changes inputs only one nanosecond after a rising edge, so each value is stable through the next edge. A counter cannot reach saturation at 32 bits within a short run, so a second instance with 4-bit counters shows saturation and the sticky flag.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    localparam int SRC_W  = 4;
    localparam int NUM_EV = 7;

    localparam logic [SRC_W-1:0] SRC_OFF   = 4'd0;
    localparam logic [SRC_W-1:0] SRC_CYCLE = 4'd1;
    localparam logic [SRC_W-1:0] SRC_EV0   = 4'd2;

    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_e;

    typedef enum logic [1:0] {
        MODE_CH2_TO_CH1 = 2'b00,
        MODE_CH1_TO_CH2 = 2'b01,
        MODE_RUN_TO_BRK = 2'b10,
        MODE_RUN_TO_BRK2 = 2'b11
    } win_mode_e;

endpackage

// File: rtl/pwc_window_fsm.sv
module pwc_window_fsm
    import pwc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       hit_ch1,
    input  logic       hit_ch2,
    input  logic       run_start,
    input  logic       brk_evt,
    output logic       win_open
);

    win_state_e state_q;
    win_state_e state_d;
    logic       open_ev;
    logic       close_ev;

    // strobe routing per mode
    always_comb begin
        unique case (win_mode_e'(mode_sel))
            MODE_CH2_TO_CH1: begin
                open_ev  = hit_ch2;
                close_ev = hit_ch1;
            end
            MODE_CH1_TO_CH2: begin
                open_ev  = hit_ch1;
                close_ev = hit_ch2;
            end
            default: begin
                open_ev  = run_start;
                close_ev = brk_evt;
            end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_CLOSED: if (open_ev && !close_ev) state_d = WIN_OPEN;
            WIN_OPEN:   if (close_ev && !open_ev) state_d = WIN_CLOSED;
            default:    state_d = WIN_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_CLOSED;
        else        state_q <= state_d;
    end

    always_comb begin
        win_open = (state_q == WIN_OPEN);
    end

    AST_MODE0_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00 && hit_ch2 && !hit_ch1) |=> win_open); // R2
    AST_MODE1_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 && hit_ch1 && !hit_ch2) |=> win_open); // R3
    AST_BRK_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[1] && brk_evt && !run_start) |=> !win_open); // R4
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (open_ev && close_ev) |=> $stable(win_open)); // R7

endmodule

// File: rtl/pwc_event_sel.sv
module pwc_event_sel
    import pwc_pkg::*;
(
    input  logic [SRC_W-1:0]  code,
    input  logic [NUM_EV-1:0] ev,
    output logic              hit
);

    always_comb begin
        hit = 1'b0;
        if (code == SRC_CYCLE) begin
            hit = 1'b1;
        end else begin
            for (int i = 0; i < NUM_EV; i++) begin
                if (code == SRC_EV0 + SRC_W'(i)) hit = ev[i];
            end
        end
    end

endmodule

// File: rtl/pwc_counter.sv
module pwc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (inc) begin
            if (&cnt_q) ovf_q <= 1'b1;
            else        cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
    assign ovf = ovf_q;

    AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !ovf_q)); // R9
    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> (ovf_q && (&cnt_q))); // R8
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R5

endmodule

// File: rtl/pwc_top.sv
module pwc_top
    import pwc_pkg::*;
#(
    parameter int  NUM_CH = 4,
    parameter int  CNT_W  = 32,
    localparam int ADDR_W = $clog2(NUM_CH + 1),
    localparam int SEL_W  = NUM_CH * SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              hit_ch1,
    input  logic              hit_ch2,
    input  logic              run_start,
    input  logic              brk_evt,
    input  logic [NUM_EV-1:0] ev_pulse,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic              init_cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              win_open
);

    logic              win_w;
    logic [NUM_CH-1:0] hit_w;
    logic [NUM_CH-1:0] ovf_w;
    logic [CNT_W-1:0]  cnt_w [NUM_CH];

    pwc_window_fsm u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .hit_ch1   (hit_ch1),
        .hit_ch2   (hit_ch2),
        .run_start (run_start),
        .brk_evt   (brk_evt),
        .win_open  (win_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwc_event_sel u_sel (
            .code (src_sel[g*SRC_W +: SRC_W]),
            .ev   (ev_pulse),
            .hit  (hit_w[g])
        );

        pwc_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (init_cmd),
            .inc   (win_w & hit_w[g]),
            .cnt   (cnt_w[g]),
            .ovf   (ovf_w[g])
        );

        AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
            (!win_open && !init_cmd) |=> $stable(cnt_w[g])); // R5
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = cnt_w[i];
        end
        if (rd_addr == ADDR_W'(NUM_CH)) rd_data[NUM_CH-1:0] = ovf_w;
    end

    assign win_open = win_w;

    AST_INIT_KEEPS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (init_cmd && !hit_ch1 && !hit_ch2 && !run_start && !brk_evt)
        |=> $stable(win_open)); // R9

endmodule

// File: tb/pwc_top_tb_top.sv
module pwc_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic [1:0]  mode;
    logic        m1, m2, rs, brk, init;
    logic [6:0]  ev;
    logic [15:0] src, src_s;
    logic [2:0]  ra, ra_s;
    logic [31:0] rd;
    logic [3:0]  rd_s;
    logic        wo, wo_s;
    int          n_chk;
    int          n_bad;
    logic [31:0] v;

    // {mode[1:0], ch1, ch2, run, brk, expected win_open}
    localparam logic [6:0] VEC [17] = '{
        7'b00_10_00_0, 7'b00_01_00_1, 7'b00_01_00_1, 7'b00_11_00_1,
        7'b00_10_00_0, 7'b00_11_00_0, 7'b01_01_00_0, 7'b01_10_00_1,
        7'b01_00_01_1, 7'b01_01_00_0, 7'b10_10_00_0, 7'b10_00_10_1,
        7'b10_01_00_1, 7'b10_00_11_1, 7'b10_00_01_0, 7'b11_00_10_1,
        7'b11_00_01_0
    };

    pwc_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode), .hit_ch1(m1), .hit_ch2(m2),
        .run_start(rs), .brk_evt(brk), .ev_pulse(ev), .src_sel(src),
        .init_cmd(init), .rd_addr(ra), .rd_data(rd), .win_open(wo)
    );

    pwc_top #(.CNT_W(4)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode), .hit_ch1(m1), .hit_ch2(m2),
        .run_start(rs), .brk_evt(brk), .ev_pulse(ev), .src_sel(src_s),
        .init_cmd(init), .rd_addr(ra_s), .rd_data(rd_s), .win_open(wo_s)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rdm(input logic [2:0] a, output logic [31:0] val);
        ra = a;
        #1;
        val = rd;
    endtask

    task automatic rds(input logic [2:0] a, output logic [31:0] val);
        ra_s = a;
        #1;
        val = {28'd0, rd_s};
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        n_chk = 0; n_bad = 0;
        rst_n = 1'b0; mode = 2'b00; m1 = 0; m2 = 0; rs = 0; brk = 0; init = 0;
        ev = '0; src = '0; src_s = '0; ra = '0; ra_s = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;

        // R11 reset state
        chk("R11 win", {31'd0, wo}, 32'd0);
        rdm(3'd0, v); chk("R11 cnt0", v, 32'd0);
        rdm(3'd4, v); chk("R11 flags", v, 32'd0);

        // R2 R3 R4 R7 window vectors
        for (int i = 0; i < 17; i++) begin
            mode = VEC[i][6:5]; m1 = VEC[i][4]; m2 = VEC[i][3];
            rs = VEC[i][2]; brk = VEC[i][1];
            tick();
            chk($sformatf("R2 R3 R4 R7 vec%0d", i), {31'd0, wo}, {31'd0, VEC[i][0]});
            m1 = 0; m2 = 0; rs = 0; brk = 0;
        end

        // R1 R5 gating: cycles, branch, interrupt, code 9
        mode = 2'b00;
        src = {4'd9, 4'd6, 4'd2, 4'd1};
        m2 = 1; ev = 7'h7F; tick(); m2 = 0;
        for (int k = 0; k < 10; k++) begin
            ev = {2'b11, (k < 5), 3'b111, (k % 3 == 0)};
            m1 = (k == 9);
            tick();
        end
        m1 = 0; ev = 7'h7F; tick(); ev = '0;
        chk("R5 closed", {31'd0, wo}, 32'd0);
        rdm(3'd0, v); chk("R5 cycles", v, 32'd10);
        rdm(3'd1, v); chk("R1 branch", v, 32'd4);
        rdm(3'd2, v); chk("R1 irq", v, 32'd5);
        rdm(3'd3, v); chk("R1 code9", v, 32'd0);

        // R6 reopen accumulates
        m2 = 1; tick(); m2 = 0;
        for (int k = 0; k < 3; k++) begin
            ev = 7'h7F; m1 = (k == 2); tick();
        end
        m1 = 0; ev = '0;
        rdm(3'd0, v); chk("R6 cycles", v, 32'd13);
        rdm(3'd1, v); chk("R6 branch", v, 32'd7);
        rdm(3'd2, v); chk("R6 irq", v, 32'd8);

        // R9 init beats increment, window untouched
        m2 = 1; tick(); m2 = 0;
        init = 1; ev = 7'h7F; tick(); init = 0; ev = '0;
        chk("R9 win kept", {31'd0, wo}, 32'd1);
        rdm(3'd0, v); chk("R9 cnt0", v, 32'd0);
        rdm(3'd1, v); chk("R9 cnt1", v, 32'd0);

        // R1 remaining codes
        src = {4'd7, 4'd5, 4'd4, 4'd3};
        ev = 7'b0000010; repeat (2) tick();
        ev = 7'b0000100; repeat (3) tick();
        ev = 7'b0001000; tick();
        ev = 7'b0100000; repeat (4) tick();
        ev = '0; m1 = 1; tick(); m1 = 0;
        rdm(3'd0, v); chk("R1 instr", v, 32'd2);
        rdm(3'd1, v); chk("R1 instr32", v, 32'd3);
        rdm(3'd2, v); chk("R1 exc", v, 32'd1);
        rdm(3'd3, v); chk("R1 dmiss", v, 32'd4);

        init = 1; tick(); init = 0;
        src = {4'd15, 4'd0, 4'd0, 4'd8};
        m2 = 1; tick(); m2 = 0;
        ev = 7'h7F; repeat (2) tick();
        ev = '0; m1 = 1; tick(); m1 = 0;
        rdm(3'd0, v); chk("R1 imiss", v, 32'd2);
        rdm(3'd1, v); chk("R1 off", v, 32'd0);
        rdm(3'd3, v); chk("R1 code15", v, 32'd0);
        rdm(3'd4, v); chk("R10 flags", v, 32'd0);
        rdm(3'd5, v); chk("R10 addr5", v, 32'd0);
        rdm(3'd7, v); chk("R10 addr7", v, 32'd0);

        // R8 saturation on 4-bit instance
        mode = 2'b10;
        src_s = 16'h0001;
        init = 1; tick(); init = 0;
        rs = 1; tick(); rs = 0;
        repeat (15) tick();
        rds(3'd0, v); chk("R8 at max", v, 32'd15);
        rds(3'd4, v); chk("R8 no flag", v, 32'd0);
        @(posedge clk); #1;
        rds(3'd0, v); chk("R8 saturated", v, 32'd15);
        rds(3'd4, v); chk("R8 flag set", v, 32'd1);
        repeat (3) tick();
        brk = 1; tick(); brk = 0;
        chk("R4 brk close", {31'd0, wo_s}, 32'd0);
        rds(3'd0, v); chk("R8 still max", v, 32'd15);
        rds(3'd4, v); chk("R8 sticky", v, 32'd1);
        init = 1; tick(); init = 0;
        rds(3'd0, v); chk("R9 clr cnt", v, 32'd0);
        rds(3'd4, v); chk("R9 clr flag", v, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule